// File: doc/BRIEF.md
# Two-Times Averaging Video Upscaler

This block doubles the size of a streamed video component plane in both directions. Pixels of one plane (luma, or a chroma plane run through its own instance) arrive in raster order with a valid strobe, an end-of-line marker and an end-of-frame marker. Every output row carries twice as many samples as an input row, and every frame carries twice as many rows. New samples are rounded averages of their neighbours.

A small input FIFO separates arrival from processing. Two row stores hold source row n and source row n+1. For each source row the block emits the widened row, with a midpoint between each pair of neighbours, and then a synthesized row made from vertical midpoints of the widened rows n and n+1. A state machine sequences the fills and the emission. The input is stalled through `in_ready` while output rows are produced, so no frame buffer is needed.

Top module: `upscale2x`

## Requirements
- R1: In a widened row, output position 2k equals source sample k and output position 2k+1 equals (s[k] + s[k+1] + 1) >> 1 for every k below W-1.
- R2: The synthesized row that follows widened row n equals, position by position, the rounded average (a + b + 1) >> 1 of widened row n and widened row n+1.
- R3: At the right edge, position 2W-1 uses s[W-1] as its missing neighbour, so it equals s[W-1]. After the last source row, row n itself replaces the missing row n+1, so the final synthesized row equals the final widened row.
- R4: Every output row has 2W samples and `out_eol` is high on its last sample only. A frame of H source rows yields 2H output rows, and `out_eof` is high only on the last sample of the last one.
- R5: `in_ready` is low exactly when the input FIFO holds FIFO_D samples. A sample offered while `in_ready` is low is not taken, and every sample taken appears in the output.
- R6: After reset, `out_valid` is low and `in_ready` is high.
- R7: For each source row, the 2W samples of its widened row come out before the 2W samples of its synthesized row, and source rows are handled in arrival order.
- R8: Within an output row, `out_valid` stays high on every cycle from the first sample to the sample marked `out_eol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input FIFO can take a sample |
| in_data | input | DW | Input sample |
| in_eol | input | 1 | Last sample of a source row |
| in_eof | input | 1 | Last sample of a frame (set together with in_eol) |
| out_valid | output | 1 | Output sample present |
| out_data | output | DW | Output sample |
| out_eol | output | 1 | Last sample of an output row |
| out_eof | output | 1 | Last sample of an output frame |

## Verification
A wrong row-store select or a stale "last row" flag shows as wrong values in the very next synthesized row, at most 2W cycles after the fault. The bench compares every output sample against a queue model, so the error is caught on that sample. A miscounted width or phase counter moves `out_eol` or `out_eof` to the wrong sample within one row. A FIFO pointer or count fault either drops or repeats an input sample, which shifts every later output value and is caught at the first affected position. Samples that change while `in_ready` is low show up as wrong values if they are taken.

// File: rtl/upscale2x.sv
module upscale2x #(
  parameter int DW     = 8,
  parameter int MAX_W  = 16,
  parameter int FIFO_D = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_eol,
  input  logic          in_eof,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_eol,
  output logic          out_eof
);
  localparam int AW  = $clog2(MAX_W);
  localparam int CW  = AW + 1;
  localparam int WW  = CW + 1;
  localparam int FAW = $clog2(FIFO_D);
  localparam int FCW = FAW + 1;
  localparam logic [CW-1:0]  ONE_C = 1;
  localparam logic [WW-1:0]  ONE_W = 1;
  localparam logic [AW-1:0]  ONE_A = 1;
  localparam logic [FAW-1:0] ONE_F = 1;
  localparam logic [FCW-1:0] FULL  = FCW'(FIFO_D);

  typedef enum logic [1:0] {S_FIRST, S_NEXT, S_EMIT} state_t;

  function automatic logic [DW-1:0] avg(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, 1'b1};
    return s[DW:1];
  endfunction

  logic [DW+1:0]  fq [FIFO_D];
  logic [FAW-1:0] fwp, frp;
  logic [FCW-1:0] fcnt;
  logic [DW-1:0]  rowm [2][MAX_W];

  state_t         st;
  logic           sel, last, nlast, half;
  logic [AW-1:0]  col;
  logic [CW-1:0]  width, p;

  logic push, pop, h_eol, h_eof, wbuf, bsel, kend, row_end;
  logic [DW-1:0] h_data, a0, a1, b0, b1, wa, wb, val;
  logic [AW-1:0] k, kn;

  assign in_ready = fcnt != FULL;
  assign push     = in_valid && in_ready;
  assign pop      = (st != S_EMIT) && (fcnt != '0);
  assign {h_eof, h_eol, h_data} = fq[frp];
  assign wbuf     = (st == S_FIRST) ? sel : ~sel;

  assign k       = p[CW-1:1];
  assign kend    = {1'b0, k} == (width - ONE_C);
  assign kn      = kend ? k : k + ONE_A;
  assign bsel    = last ? sel : ~sel;
  assign a0      = rowm[sel][k];
  assign a1      = rowm[sel][kn];
  assign b0      = rowm[bsel][k];
  assign b1      = rowm[bsel][kn];
  assign wa      = p[0] ? avg(a0, a1) : a0;
  assign wb      = p[0] ? avg(b0, b1) : b0;
  assign val     = half ? avg(wa, wb) : wa;
  assign row_end = {1'b0, p} == ({width, 1'b0} - ONE_W);

  always_ff @(posedge clk) begin
    if (push) fq[fwp] <= {in_eof, in_eol, in_data};
    if (pop)  rowm[wbuf][col] <= h_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwp <= '0; frp <= '0; fcnt <= '0;
      st <= S_FIRST; sel <= 1'b0; last <= 1'b0; nlast <= 1'b0; half <= 1'b0;
      col <= '0; width <= '0; p <= '0;
      out_valid <= 1'b0; out_data <= '0; out_eol <= 1'b0; out_eof <= 1'b0;
    end else begin
      if (push) fwp <= fwp + ONE_F;
      if (pop)  frp <= frp + ONE_F;
      case ({push, pop})
        2'b10:   fcnt <= fcnt + 1'b1;
        2'b01:   fcnt <= fcnt - 1'b1;
        default: ;
      endcase

      case (st)
        S_FIRST: if (pop) begin
          col <= col + ONE_A;
          if (h_eol) begin
            width <= {1'b0, col} + ONE_C;
            col   <= '0;
            if (h_eof) begin last <= 1'b1; st <= S_EMIT; end
            else st <= S_NEXT;
          end
        end
        S_NEXT: if (pop) begin
          col <= col + ONE_A;
          if (h_eol) begin col <= '0; nlast <= h_eof; st <= S_EMIT; end
        end
        default: begin
          if (!row_end) p <= p + ONE_C;
          else begin
            p <= '0;
            if (!half) half <= 1'b1;
            else begin
              half <= 1'b0;
              if (last) begin last <= 1'b0; st <= S_FIRST; end
              else begin
                sel  <= ~sel;
                last <= nlast;
                st   <= nlast ? S_EMIT : S_NEXT;
              end
            end
          end
        end
      endcase

      out_valid <= st == S_EMIT;
      out_data  <= (st == S_EMIT) ? val : '0;
      out_eol   <= (st == S_EMIT) && row_end;
      out_eof   <= (st == S_EMIT) && row_end && half && last;
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt == FULL) |=> (fcnt == FULL) || $past(pop));
  p_no_fill_during_emit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EMIT) |=> fcnt >= $past(fcnt));
  p_eof_on_eol_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_eol && out_valid);
  p_eol_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> out_valid);
  p_row_gapless_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eol) |=> out_valid);
endmodule

// File: tb/upscale2x_bench.sv
`timescale 1ns/1ps
module upscale2x_bench;
  localparam int DW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_eol = 1'b0, in_eof = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_eol, out_eof;
  logic [DW-1:0] out_data;

  typedef struct { int d; bit eol; bit eof; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  int pix[16][16];
  bit in_row = 0;

  always #2 clk = ~clk;

  upscale2x #(.DW(DW), .MAX_W(16), .FIFO_D(4)) u_upscale2x (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_eol(in_eol), .in_eof(in_eof), .out_valid(out_valid),
    .out_data(out_data), .out_eol(out_eol), .out_eof(out_eof));

  function automatic int av(int a, int b);
    return (a + b + 1) >> 1;
  endfunction

  function automatic int wid(int r, int j, int w);
    int k = j / 2;
    int kn = (k + 1 < w) ? k + 1 : w - 1;
    if (j % 2 == 0) return pix[r][k];
    return av(pix[r][k], pix[r][kn]);
  endfunction

  function automatic string htag(int j, int w);
    if (j % 2 == 0) return "R7";
    return (j == 2*w - 1) ? "R3" : "R1";
  endfunction

  task automatic send_frame(int w, int h, int mode, bit gaps);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        pix[r][c] = (mode == 0) ? $urandom_range(0, 255) : ((mode == 1) ? 255 : ((c + r) % 2) * 255);
    for (int r = 0; r < h; r++) begin
      int rn = (r + 1 < h) ? r + 1 : h - 1;
      for (int j = 0; j < 2*w; j++)
        q.push_back('{wid(r, j, w), j == 2*w-1, 1'b0, htag(j, w)});
      for (int j = 0; j < 2*w; j++)
        q.push_back('{av(wid(r, j, w), wid(rn, j, w)), j == 2*w-1,
                      (r == h-1) && (j == 2*w-1), (r == h-1) ? "R3" : "R2"});
    end
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        if (gaps && ($urandom_range(0, 2) == 0)) begin
          @(negedge clk); in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1; in_eol = (c == w-1); in_eof = (c == w-1) && (r == h-1);
        in_data = DW'(pix[r][c]);
        while (!in_ready) begin
          in_data = ~DW'(pix[r][c]);
          @(negedge clk);
          in_data = DW'(pix[r][c]);
        end
        @(posedge clk);
      end
    @(negedge clk);
    in_valid = 1'b0; in_eol = 1'b0; in_eof = 1'b0;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        fails++; $display("FAIL R4: extra output %0d, expected none", out_data);
      end else begin
        e = q.pop_front();
        if (int'(out_data) != e.d) begin
          fails++; $display("FAIL %s: data %0d expected %0d", e.tag, out_data, e.d);
        end
        checks++;
        if (out_eol != e.eol || out_eof != e.eof) begin
          fails++; $display("FAIL R4: eol/eof %0b/%0b expected %0b/%0b", out_eol, out_eof, e.eol, e.eof);
        end
      end
      in_row = !out_eol;
    end else if (in_row) begin
      checks++; fails++;
      $display("FAIL R8: out_valid 0 mid-row, expected 1");
      in_row = 0;
    end
  end

  initial begin
    bit done = 0;
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
          fails++; $display("FAIL R6: valid/ready %b/%b expected 0/1", out_valid, in_ready);
        end
        send_frame(8, 6, 0, 0);
        send_frame(8, 6, 0, 1);
        send_frame(8, 6, 1, 0);
        send_frame(8, 6, 2, 1);
        send_frame(1, 1, 0, 0);
        send_frame(3, 1, 0, 0);
        send_frame(2, 2, 0, 1);
        send_frame(8, 6, 0, 0);
        while (q.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
          fails++; $display("FAIL R5: idle valid/ready %b/%b expected 0/1", out_valid, in_ready);
        end
        done = 1;
      end
      begin
        repeat (100000) @(posedge clk);
      end
    join_any
    disable fork;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R4: watchdog expired, %0d outputs pending, expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule